// File: doc/BRIEF.md
# Transceiver Reset Sequencer with Strap Capture

This block merges two reset sources into one internal reset for the management and configuration logic of a line transceiver. The first source is an active-low board reset pin. The pin is brought into the clock domain and is accepted only after it has stayed low for a minimum time. Shorter low pulses are treated as glitches. The second source is a software request. A host write that sets the trigger bit of the control word starts the reset. That bit reads back as 1 while the reset runs and clears itself when the reset ends.

While either reset is active, the shared configuration/LED pads are kept tri-stated. On the last clock of the reset window the block samples their levels and holds them as the power-up defaults of the configurable registers. One cycle after reset ends, the pad output enable rises so the pads can act as LED outputs again. A done flag rises when the internal reset releases and falls when the next reset begins. A separate power-on input initialises the sequencer itself.

Every pin is a plain level or a single-cycle strobe. No stream interface is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `xcvr_reset_seq`

## Requirements
- R1: While `por_n` is low, `core_rst_n`, `strap_oe`, `rst_done` and `ctl_rst_bit` are 0. On the first clock edge after `por_n` goes high, `core_rst_n` rises, `rst_done` rises and `cfg_dflt` takes the current `strap_pad_i`.
- R2: If `rst_pin_n` is low for at least MIN_LOW_CYC consecutive clock samples, `core_rst_n` drops and stays low while the pin remains low. MIN_LOW_CYC is CLK_HZ times MIN_LOW_US divided by one million. A low pulse of MIN_LOW_CYC-1 samples has no effect.
- R3: A clock edge that sees `ctl_we` high and `ctl_wdata` bit 15 at 1, with no reset in progress, starts a software reset. `ctl_rst_bit` reads 1 right after that edge, and `core_rst_n` falls one edge later.
- R4: `ctl_rst_bit` clears by itself SWR_CYC edges after the triggering edge. `core_rst_n` rises on the following edge.
- R5: A write with bit 15 at 0 has no effect. A write while a reset is in progress has no effect and does not extend the reset.
- R6: `strap_oe` is 0 whenever `core_rst_n` is 0.
- R7: `strap_oe` rises exactly one edge after `core_rst_n` rises.
- R8: `cfg_dflt` is loaded from `strap_pad_i` on the edge where `core_rst_n` rises. While out of reset, later pad changes leave it unchanged.
- R9: `rst_done` rises together with `core_rst_n` and clears on the edge where `core_rst_n` falls.
- R10: Both the hardware and the software reset re-capture the straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on initialisation of the sequencer, active low |
| rst_pin_n | input | 1 | Board reset pin, active low, asynchronous |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_wdata | input | CTL_W | Control-word write data; bit 15 triggers software reset |
| strap_pad_i | input | STRAP_W | Input levels of the shared strap/LED pads |
| ctl_rst_bit | output | 1 | Readback of the self-clearing reset bit |
| core_rst_n | output | 1 | Internal reset for downstream logic, active low |
| rst_done | output | 1 | Set when reset releases, cleared when a reset begins |
| strap_oe | output | 1 | Output enable of the shared pads |
| cfg_dflt | output | STRAP_W | Captured strap values, used as register defaults |

## Verification
The bench drives a board-reset pulse exactly one sample short of the threshold and then one exactly at it. A qualifier that is off by one would either miss the valid pulse or reset on the glitch. It retriggers the software reset mid-window and checks that release still lands on the expected edge; a design that reloads its counter would release late. It changes the pads just before release and again afterwards. Capturing one cycle early or late, or letting the captured values follow the pads, shows up as a wrong `cfg_dflt`. It also checks the exact edges of `strap_oe` and `rst_done`, which catch an enable that turns on together with release or a done flag that is never cleared.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  function automatic int unsigned low_cycles(input int unsigned clk_hz, input int unsigned us);
    return (clk_hz / 1000) * us / 1000;
  endfunction
endpackage

// File: rtl/rstseq_pin_qual.sv
module rstseq_pin_qual #(
  parameter int unsigned MIN_CYC = 100
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic hw_rst
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      cnt    <= '0;
      hw_rst <= 1'b0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      if (s2) begin
        cnt    <= '0;
        hw_rst <= 1'b0;
      end else if (cnt == LAST) begin
        hw_rst <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the qualified reset only starts after the synchronised pin was low
  a_r2_needs_low: assert property (@(posedge clk) disable iff (!por_n)
    $rose(hw_rst) |-> $past(!s2));
  a_r2_drops_on_high: assert property (@(posedge clk) disable iff (!por_n)
    (hw_rst && s2) |=> !hw_rst);
endmodule

// File: rtl/rstseq_soft.sv
module rstseq_soft #(
  parameter int unsigned SWR_CYC  = 8,
  parameter int unsigned CTL_W    = 16,
  parameter int unsigned TRIG_BIT = 15
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             busy,
  output logic             sw_act
);
  localparam int unsigned CW = (SWR_CYC > 1) ? $clog2(SWR_CYC) : 1;

  logic [CW-1:0] cnt;
  logic          trig;

  assign trig = we && wdata[TRIG_BIT] && !busy && !sw_act;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_act <= 1'b0;
      cnt    <= '0;
    end else if (sw_act) begin
      if (cnt == '0) sw_act <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end else if (trig) begin
      sw_act <= 1'b1;
      cnt    <= CW'(SWR_CYC - 1);
    end
  end

  // R3: a valid trigger write starts the software reset
  a_r3_starts: assert property (@(posedge clk) disable iff (!por_n)
    (we && wdata[TRIG_BIT] && !busy && !sw_act) |=> sw_act);
  // R5: a write without the trigger bit never starts a reset
  a_r5_no_bit_no_start: assert property (@(posedge clk) disable iff (!por_n)
    (!sw_act && !(we && wdata[TRIG_BIT])) |=> !sw_act);
endmodule

// File: rtl/rstseq_strap.sv
module rstseq_strap #(
  parameter int unsigned STRAP_W = 4
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_any,
  input  logic [STRAP_W-1:0] pads,
  output logic               core_rst_n,
  output logic               oe,
  output logic               done,
  output logic [STRAP_W-1:0] cfg
);
  logic release_now;
  assign release_now = !core_rst_n && !rst_any;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      core_rst_n <= 1'b0;
      oe         <= 1'b0;
      done       <= 1'b0;
      cfg        <= '0;
    end else begin
      core_rst_n <= !rst_any;
      oe         <= core_rst_n && !rst_any;
      if (release_now) begin
        cfg  <= pads;
        done <= 1'b1;
      end else if (rst_any) begin
        done <= 1'b0;
      end
    end
  end

  a_r6_oe_off_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    !core_rst_n |-> !oe);
  a_r7_oe_lag: assert property (@(posedge clk) disable iff (!por_n)
    $rose(oe) |-> $past(core_rst_n));
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst_n && $past(core_rst_n)) |-> $stable(cfg));
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst_n) |-> !done);
endmodule

// File: rtl/xcvr_reset_seq.sv
module xcvr_reset_seq #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned MIN_LOW_US = 1000,
  parameter int unsigned SWR_CYC    = 8,
  parameter int unsigned CTL_W      = 16,
  parameter int unsigned STRAP_W    = 4
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_pin_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic [STRAP_W-1:0] strap_pad_i,
  output logic               ctl_rst_bit,
  output logic               core_rst_n,
  output logic               rst_done,
  output logic               strap_oe,
  output logic [STRAP_W-1:0] cfg_dflt
);
  import rstseq_pkg::*;
  localparam int unsigned MIN_LOW_CYC = low_cycles(CLK_HZ, MIN_LOW_US);
  localparam int unsigned TRIG_BIT    = 15;

  logic hw_rst, sw_act, rst_any;

  rstseq_pin_qual #(.MIN_CYC(MIN_LOW_CYC)) u_qual (
    .clk(clk), .por_n(por_n), .pin_n(rst_pin_n), .hw_rst(hw_rst));

  rstseq_soft #(.SWR_CYC(SWR_CYC), .CTL_W(CTL_W), .TRIG_BIT(TRIG_BIT)) u_soft (
    .clk(clk), .por_n(por_n), .we(ctl_we), .wdata(ctl_wdata),
    .busy(!core_rst_n), .sw_act(sw_act));

  assign rst_any     = hw_rst | sw_act;
  assign ctl_rst_bit = sw_act;

  rstseq_strap #(.STRAP_W(STRAP_W)) u_strap (
    .clk(clk), .por_n(por_n), .rst_any(rst_any), .pads(strap_pad_i),
    .core_rst_n(core_rst_n), .oe(strap_oe), .done(rst_done), .cfg(cfg_dflt));

  // R4: the reset bit is only ever cleared while the internal reset is held
  a_r4_clear_inside: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ctl_rst_bit) |-> !core_rst_n);
endmodule

// File: tb/sim_xcvr_reset_seq.sv
module sim_xcvr_reset_seq;
  localparam int MINC = 100;
  localparam int SWR  = 8;

  logic clk = 0, por_n = 0, rst_pin_n = 1, ctl_we = 0;
  logic [15:0] ctl_wdata = '0;
  logic [3:0]  strap_pad_i = 4'hA;
  logic ctl_rst_bit, core_rst_n, rst_done, strap_oe;
  logic [3:0] cfg_dflt;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  xcvr_reset_seq #(.CLK_HZ(50_000_000), .MIN_LOW_US(2), .SWR_CYC(SWR)) u0 (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .strap_pad_i(strap_pad_i), .ctl_rst_bit(ctl_rst_bit),
    .core_rst_n(core_rst_n), .rst_done(rst_done), .strap_oe(strap_oe),
    .cfg_dflt(cfg_dflt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic t_por();
    #1;
    chk("R1 core_rst_n", core_rst_n, 0); chk("R1 oe", strap_oe, 0);
    chk("R1 done", rst_done, 0); chk("R1 bit", ctl_rst_bit, 0);
    step(); por_n = 1;
    step();
    chk("R1 release", core_rst_n, 1); chk("R1 done", rst_done, 1);
    chk("R1 cfg", cfg_dflt, 4'hA); chk("R7 oe still off", strap_oe, 0);
    step();
    chk("R7 oe on", strap_oe, 1);
  endtask

  task automatic t_sw();
    ctl_we = 1; ctl_wdata = 16'h7FFF; step(); ctl_we = 0;
    step();
    chk("R5 no bit", ctl_rst_bit, 0); chk("R5 no reset", core_rst_n, 1);
    ctl_we = 1; ctl_wdata = 16'h8000; step(); ctl_we = 0;   // edge E0
    chk("R3 bit set", ctl_rst_bit, 1); chk("R3 core still up", core_rst_n, 1);
    step();                                                 // E0+1
    chk("R3 core down", core_rst_n, 0); chk("R9 done cleared", rst_done, 0);
    chk("R6 oe off", strap_oe, 0);
    ctl_we = 1; ctl_wdata = 16'hFFFF; step(); ctl_we = 0;   // E0+2 retrigger
    strap_pad_i = 4'h5;
    for (int i = 0; i < SWR - 2; i++) step();               // E0+SWR
    chk("R4 bit cleared", ctl_rst_bit, 0); chk("R5 not extended", core_rst_n, 0);
    step();                                                 // E0+SWR+1
    chk("R4 release", core_rst_n, 1); chk("R9 done set", rst_done, 1);
    chk("R10 sw cfg", cfg_dflt, 4'h5); chk("R7 oe still off", strap_oe, 0);
    step();
    chk("R7 oe on", strap_oe, 1);
    strap_pad_i = 4'hF; step(); step();
    chk("R8 cfg held", cfg_dflt, 4'h5);
  endtask

  task automatic t_hw();
    bit dipped = 0;
    int n;
    rst_pin_n = 0;
    for (int i = 0; i < MINC - 1; i++) step();
    rst_pin_n = 1;
    for (int i = 0; i < 10; i++) begin step(); if (!core_rst_n) dipped = 1; end
    chk("R2 glitch ignored", dipped, 0);
    strap_pad_i = 4'h3;
    rst_pin_n = 0;
    for (int i = 0; i < MINC; i++) step();
    rst_pin_n = 1;
    n = 0;
    while (core_rst_n && n < 20) begin step(); n++; end
    chk("R2 accepted", core_rst_n, 0); chk("R9 done cleared", rst_done, 0);
    chk("R6 oe off", strap_oe, 0);
    strap_pad_i = 4'h6;
    n = 0;
    while (!core_rst_n && n < 20) begin step(); n++; end
    chk("R10 hw cfg", cfg_dflt, 4'h6); chk("R9 done set", rst_done, 1);
    chk("R7 oe still off", strap_oe, 0);
    step(); chk("R7 oe on", strap_oe, 1);
    rst_pin_n = 0;
    for (int i = 0; i < MINC + 20; i++) step();
    chk("R2 held while low", core_rst_n, 0);
    rst_pin_n = 1;
    for (int i = 0; i < 8; i++) step();
    chk("R2 released", core_rst_n, 1);
  endtask

  initial begin
    t_por();
    t_sw();
    t_hw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule